// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block runs a narrow external memory bus on which one port carries the low address byte first and the data byte after it, while a second port carries the high address byte. Each machine cycle is a fixed grid of twelve clock slots: six states, each split into two phases. The block places the address, the address latch pulse, the turnaround gap, the strobes and the read sample on fixed slots of that grid. It serves two kinds of transaction. A code read is a program-memory fetch that uses the program strobe. A data read or data write is a data-memory transfer that uses the read or write strobe.

A client holds a request, with its kind, a 16-bit address and write data, until `req_accept_o` pulses. A code read runs entirely in the machine cycle after it is accepted. A data transfer puts its address on the bus in the last two states of the cycle in which it is accepted, and runs its strobe in the next cycle. No fetch takes place in that next cycle. Read bytes come back on `rd_data_o` with a one-clock `rd_valid_o`. The external address latch, the pads and the memories are outside the block.

Top module: `ext_bus_seq`

## Requirements
- R1: While `rst_ni` is low, `psen_n_o`, `rd_n_o` and `wr_n_o` are 1, and `ale_o`, `port_oe_o`, `rd_valid_o` and `req_accept_o` are 0. Slots are numbered 0..11, where slot 2*(s-1)+(p-1) is state s, phase p. Slot 0 is the first clock after reset is released, and the count wraps from 11 to 0.
- R2: In a code-read cycle, the low port drives the low address byte with `port_oe_o`=1 in slots 0..2. `ale_o` is 1 in slots 1..2. `addr_hi_o` shows the high address byte from slot 0 through at least slot 7.
- R3: In a code-read cycle, the low port is released in slot 3, which is the turnaround gap. `psen_n_o` is 0 only in slots 4..6.
- R4: A code read samples `port_din_i` at the end of slot 6. `rd_valid_o` is 1 for exactly one clock, in slot 7, with that byte on `rd_data_o`.
- R5: A data transfer accepted in cycle N drives the low address byte with `port_oe_o`=1 in slots 8..11 of cycle N, with `ale_o`=1 in slots 9..10. `addr_hi_o` shows the high address byte from slot 8 of cycle N to the end of cycle N+1 and does not change in that span.
- R6: A data read (kind 2'b01) drives `rd_n_o`=0 only in slots 2..9 of cycle N+1 and never drives the low port in that cycle. It samples `port_din_i` at the end of slot 9 and shows the byte with `rd_valid_o`=1 in slot 10.
- R7: A data write (kind 2'b10) releases the low port in slot 0 of cycle N+1. It drives the write byte with `port_oe_o`=1 in slots 1..10 and drives `wr_n_o`=0 only in slots 2..9.
- R8: At most one of `psen_n_o`, `rd_n_o`, `wr_n_o` is low at a time, and `psen_n_o` stays 1 throughout a data-transfer cycle.
- R9: `port_oe_o` is 0 whenever `psen_n_o` or `rd_n_o` is 0.
- R10: Requests are accepted only in slot 7, and `req_accept_o` pulses in that slot. Code is kind 2'b00. Kind 2'b11 is never accepted and causes no bus activity. A data request is held off while the current cycle is itself a data-transfer cycle, so two data transfers are accepted 24 clocks apart, and a request after a data transfer is accepted 12 clocks later.
- R11: `rd_valid_o` pulses once per accepted read, in acceptance order, and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one slot per period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request held until accepted |
| req_kind_i | input | 2 | 00 code read, 01 data read, 10 data write, 11 none |
| req_addr_i | input | 16 | Transaction address |
| req_wdata_i | input | 8 | Byte to write |
| req_accept_o | output | 1 | Request taken this clock |
| port_din_i | input | 8 | Value read back from the shared low port |
| port_do_o | output | 8 | Drive value of the shared low port |
| port_oe_o | output | 1 | Output enable of the shared low port |
| addr_hi_o | output | 8 | High address port |
| ale_o | output | 1 | Address latch pulse for the low byte |
| psen_n_o | output | 1 | Program read strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| rd_data_o | output | 8 | Byte returned by a read |
| rd_valid_o | output | 1 | One-clock valid for rd_data_o |

## Verification
Code reads are run at the address extremes 0x0000 and 0xFFFF and at mixed patterns. These checks separate a wrong low byte, which is taken from the port while the latch pulse is high, from a wrong high byte on its own port. A data write followed at once by a read of the same address shows the write byte reaching memory and tests the 24-clock hold-off between transfers. A request with kind 11 shows that nothing is accepted and no strobe moves. An interleaved mix of fetches and transfers tests in-order return and the 12-clock spacing after a transfer, while every strobe, latch pulse and valid flag is checked against its slot window.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;

  typedef enum logic [1:0] {
    K_CODE = 2'b00,
    K_DRD  = 2'b01,
    K_DWR  = 2'b10,
    K_NONE = 2'b11
  } kind_e;

  // machine-cycle grid: slot = 2*(state-1) + (phase-1)
  localparam int unsigned SLOTS  = 12;
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  localparam logic [SLOT_W-1:0] SL_LAST      = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] C_ADDR_END   = 4'd2;
  localparam logic [SLOT_W-1:0] C_ALE_FIRST  = 4'd1;
  localparam logic [SLOT_W-1:0] C_ALE_LAST   = 4'd2;
  localparam logic [SLOT_W-1:0] C_PSEN_FIRST = 4'd4;
  localparam logic [SLOT_W-1:0] C_PSEN_LAST  = 4'd6;
  localparam logic [SLOT_W-1:0] C_HI_LAST    = 4'd7;
  localparam logic [SLOT_W-1:0] ACCEPT_SLOT  = 4'd7;
  localparam logic [SLOT_W-1:0] D_ADDR_FIRST = 4'd8;
  localparam logic [SLOT_W-1:0] D_ALE_FIRST  = 4'd9;
  localparam logic [SLOT_W-1:0] D_ALE_LAST   = 4'd10;
  localparam logic [SLOT_W-1:0] D_STB_FIRST  = 4'd2;
  localparam logic [SLOT_W-1:0] D_STB_LAST   = 4'd9;
  localparam logic [SLOT_W-1:0] W_DRV_FIRST  = 4'd1;
  localparam logic [SLOT_W-1:0] W_DRV_LAST   = 4'd10;

  function automatic logic in_win(logic [SLOT_W-1:0] s, logic [SLOT_W-1:0] lo,
                                  logic [SLOT_W-1:0] hi);
    return (s >= lo) && (s <= hi);
  endfunction

  function automatic logic is_data(kind_e k);
    return (k == K_DRD) || (k == K_DWR);
  endfunction

endpackage

// File: rtl/bus_slot_timer.sv
module bus_slot_timer
  import ext_bus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [SLOT_W-1:0] slot_q_o,
  output logic [SLOT_W-1:0] slot_d_o
);
  logic [SLOT_W-1:0] slot_q;

  always_comb slot_d_o = (slot_q == SL_LAST) ? '0 : slot_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= slot_d_o;
  end

  assign slot_q_o = slot_q;
endmodule

// File: rtl/bus_slot_decode.sv
module bus_slot_decode
  import ext_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              cur_v_i,
  input  kind_e             cur_kind_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [DATA_W-1:0] cur_wdata_i,
  input  logic              pend_v_i,
  input  kind_e             pend_kind_i,
  input  logic [ADDR_W-1:0] pend_addr_i,
  input  logic [HI_W-1:0]   hi_hold_i,
  output logic              ale_o,
  output logic              psen_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] lo_o,
  output logic [HI_W-1:0]   hi_o
);
  always_comb begin
    ale_o    = 1'b0;
    psen_n_o = 1'b1;
    rd_n_o   = 1'b1;
    wr_n_o   = 1'b1;
    oe_o     = 1'b0;
    lo_o     = '0;
    hi_o     = hi_hold_i;

    if (cur_v_i) begin
      unique case (cur_kind_i)
        K_CODE: begin
          if (slot_i <= C_ADDR_END) begin
            oe_o = 1'b1;
            lo_o = cur_addr_i[DATA_W-1:0];
          end
          if (in_win(slot_i, C_ALE_FIRST, C_ALE_LAST))   ale_o = 1'b1;
          if (in_win(slot_i, C_PSEN_FIRST, C_PSEN_LAST)) psen_n_o = 1'b0;
          if (slot_i <= C_HI_LAST) hi_o = cur_addr_i[ADDR_W-1:DATA_W];
        end
        K_DRD: begin
          hi_o = cur_addr_i[ADDR_W-1:DATA_W];
          if (in_win(slot_i, D_STB_FIRST, D_STB_LAST)) rd_n_o = 1'b0;
        end
        K_DWR: begin
          hi_o = cur_addr_i[ADDR_W-1:DATA_W];
          if (in_win(slot_i, W_DRV_FIRST, W_DRV_LAST)) begin
            oe_o = 1'b1;
            lo_o = cur_wdata_i;
          end
          if (in_win(slot_i, D_STB_FIRST, D_STB_LAST)) wr_n_o = 1'b0;
        end
        default: ;
      endcase
    end

    // address phase of a transfer that runs in the next cycle
    if (pend_v_i && is_data(pend_kind_i) && slot_i >= D_ADDR_FIRST) begin
      oe_o = 1'b1;
      lo_o = pend_addr_i[DATA_W-1:0];
      hi_o = pend_addr_i[ADDR_W-1:DATA_W];
      if (in_win(slot_i, D_ALE_FIRST, D_ALE_LAST)) ale_o = 1'b1;
    end
  end
endmodule

// File: rtl/bus_rd_capture.sv
module bus_rd_capture
  import ext_bus_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              cur_v_i,
  input  kind_e             cur_kind_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic cap;

  // sample in the last strobe slot
  always_comb
    cap = cur_v_i && (((cur_kind_i == K_CODE) && (slot_i == C_PSEN_LAST)) ||
                      ((cur_kind_i == K_DRD)  && (slot_i == D_STB_LAST)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= cap;
      if (cap) data_o <= din_i;
    end
  end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ext_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_accept_o,
  input  logic [DATA_W-1:0] port_din_i,
  output logic [DATA_W-1:0] port_do_o,
  output logic              port_oe_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic              ale_o,
  output logic              psen_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  logic [SLOT_W-1:0] slot_q, slot_d;

  logic              cur_v_q, cur_v_d, pend_v_q, pend_v_d;
  kind_e             cur_kind_q, cur_kind_d, pend_kind_q, pend_kind_d;
  logic [ADDR_W-1:0] cur_addr_q, cur_addr_d, pend_addr_q, pend_addr_d;
  logic [DATA_W-1:0] cur_wd_q, cur_wd_d, pend_wd_q, pend_wd_d;
  kind_e             req_kind;
  logic              accept;

  logic              ale_d, psen_n_d, rd_n_d, wr_n_d, oe_d;
  logic [DATA_W-1:0] lo_d;
  logic [HI_W-1:0]   hi_d;

  bus_slot_timer u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .slot_q_o (slot_q),
    .slot_d_o (slot_d)
  );

  always_comb begin
    req_kind = kind_e'(req_kind_i);
    // one data transfer per two machine cycles: no address phase during an access cycle
    accept = req_i && (slot_q == ACCEPT_SLOT) && (req_kind != K_NONE) &&
             !(is_data(req_kind) && cur_v_q && is_data(cur_kind_q));
  end

  assign req_accept_o = accept;

  always_comb begin
    cur_v_d     = cur_v_q;
    cur_kind_d  = cur_kind_q;
    cur_addr_d  = cur_addr_q;
    cur_wd_d    = cur_wd_q;
    pend_v_d    = pend_v_q;
    pend_kind_d = pend_kind_q;
    pend_addr_d = pend_addr_q;
    pend_wd_d   = pend_wd_q;
    if (accept) begin
      pend_v_d    = 1'b1;
      pend_kind_d = req_kind;
      pend_addr_d = req_addr_i;
      pend_wd_d   = req_wdata_i;
    end
    if (slot_q == SL_LAST) begin
      cur_v_d    = pend_v_q;
      cur_kind_d = pend_kind_q;
      cur_addr_d = pend_addr_q;
      cur_wd_d   = pend_wd_q;
      pend_v_d   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_v_q     <= 1'b0;
      cur_kind_q  <= K_NONE;
      cur_addr_q  <= '0;
      cur_wd_q    <= '0;
      pend_v_q    <= 1'b0;
      pend_kind_q <= K_NONE;
      pend_addr_q <= '0;
      pend_wd_q   <= '0;
    end else begin
      cur_v_q     <= cur_v_d;
      cur_kind_q  <= cur_kind_d;
      cur_addr_q  <= cur_addr_d;
      cur_wd_q    <= cur_wd_d;
      pend_v_q    <= pend_v_d;
      pend_kind_q <= pend_kind_d;
      pend_addr_q <= pend_addr_d;
      pend_wd_q   <= pend_wd_d;
    end
  end

  // decode the coming slot so the registered pins line up with slot_q
  bus_slot_decode #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_decode (
    .slot_i      (slot_d),
    .cur_v_i     (cur_v_d),
    .cur_kind_i  (cur_kind_d),
    .cur_addr_i  (cur_addr_d),
    .cur_wdata_i (cur_wd_d),
    .pend_v_i    (pend_v_d),
    .pend_kind_i (pend_kind_d),
    .pend_addr_i (pend_addr_d),
    .hi_hold_i   (addr_hi_o),
    .ale_o       (ale_d),
    .psen_n_o    (psen_n_d),
    .rd_n_o      (rd_n_d),
    .wr_n_o      (wr_n_d),
    .oe_o        (oe_d),
    .lo_o        (lo_d),
    .hi_o        (hi_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ale_o     <= 1'b0;
      psen_n_o  <= 1'b1;
      rd_n_o    <= 1'b1;
      wr_n_o    <= 1'b1;
      port_oe_o <= 1'b0;
      port_do_o <= '0;
      addr_hi_o <= '0;
    end else begin
      ale_o     <= ale_d;
      psen_n_o  <= psen_n_d;
      rd_n_o    <= rd_n_d;
      wr_n_o    <= wr_n_d;
      port_oe_o <= oe_d;
      port_do_o <= lo_d;
      addr_hi_o <= hi_d;
    end
  end

  bus_rd_capture #(
    .DATA_W (DATA_W)
  ) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_i     (slot_q),
    .cur_v_i    (cur_v_q),
    .cur_kind_i (cur_kind_q),
    .din_i      (port_din_i),
    .data_o     (rd_data_o),
    .valid_o    (rd_valid_o)
  );
endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk
  import ext_bus_pkg::*;
#(
  parameter int unsigned HI_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SLOT_W-1:0] slot_i,
  input logic              cur_v_i,
  input kind_e             cur_kind_i,
  input logic              pend_v_i,
  input kind_e             pend_kind_i,
  input logic              psen_n_i,
  input logic              rd_n_i,
  input logic              wr_n_i,
  input logic              ale_i,
  input logic              oe_i,
  input logic [HI_W-1:0]   hi_i,
  input logic              valid_i,
  input logic              accept_i
);
  logic cur_data, pend_data;
  assign cur_data  = cur_v_i && is_data(cur_kind_i);
  assign pend_data = pend_v_i && is_data(pend_kind_i);

  assert_strobe_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~psen_n_i, ~rd_n_i, ~wr_n_i}) <= 1);

  assert_no_fetch_in_access_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_data |-> psen_n_i);

  assert_bus_free_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!psen_n_i || !rd_n_i) |-> !oe_i);

  assert_psen_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psen_n_i |-> (slot_i >= C_PSEN_FIRST && slot_i <= C_PSEN_LAST));

  assert_ale_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_i |-> (oe_i && ((slot_i >= C_ALE_FIRST && slot_i <= C_ALE_LAST) ||
                        (slot_i >= D_ALE_FIRST && slot_i <= D_ALE_LAST))));

  assert_strobe_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_i || !wr_n_i) |-> (slot_i >= D_STB_FIRST && slot_i <= D_STB_LAST));

  assert_valid_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  assert_valid_slot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (slot_i == C_HI_LAST || slot_i == D_ALE_LAST));

  assert_accept_slot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |-> (slot_i == ACCEPT_SLOT));

  assert_single_transfer_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cur_data && pend_data));

  assert_hi_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_data && slot_i != '0) |-> $stable(hi_i));
endmodule

bind ext_bus_seq ext_bus_seq_chk #(
  .HI_W (ADDR_W - DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .slot_i      (slot_q),
  .cur_v_i     (cur_v_q),
  .cur_kind_i  (cur_kind_q),
  .pend_v_i    (pend_v_q),
  .pend_kind_i (pend_kind_q),
  .psen_n_i    (psen_n_o),
  .rd_n_i      (rd_n_o),
  .wr_n_i      (wr_n_o),
  .ale_i       (ale_o),
  .oe_i        (port_oe_o),
  .hi_i        (addr_hi_o),
  .valid_i     (rd_valid_o),
  .accept_i    (req_accept_o)
);

// File: tb/sim_ext_bus_seq.sv
module sim_ext_bus_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  kind = 2'b11;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        accept;
  logic [7:0]  din, pdo, hi, rdata;
  logic        poe, ale, psen_n, rd_n, wr_n, rvalid;

  always #10 clk = ~clk;

  ext_bus_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_kind_i(kind),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_accept_o(accept),
    .port_din_i(din), .port_do_o(pdo), .port_oe_o(poe), .addr_hi_o(hi),
    .ale_o(ale), .psen_n_o(psen_n), .rd_n_o(rd_n), .wr_n_o(wr_n),
    .rd_data_o(rdata), .rd_valid_o(rvalid)
  );

  int nchk = 0, nerr = 0;
  int cyc = 0;
  int bslot = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string r, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) bslot <= (bslot == 11) ? 0 : bslot + 1;
  end

  // external memories with a latch for the low address byte
  logic [7:0] lat_lo = '0;
  logic [7:0] dmem [0:255];
  logic [7:0] shadow [0:255];

  function automatic logic [7:0] code_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  function automatic logic [7:0] midx(input logic [15:0] a);
    return a[7:0] ^ a[15:8];
  endfunction

  always_comb begin
    if (!psen_n)    din = code_byte({hi, lat_lo});
    else if (!rd_n) din = dmem[lat_lo ^ hi];
    else            din = 8'hEE;
  end

  always @(posedge wr_n) if (rst_n) dmem[lat_lo ^ hi] <= pdo;

  typedef struct { logic [1:0] k; logic [15:0] a; logic [7:0] d; } exp_t;
  exp_t sb[$];
  int last_acc = 0;
  int quiet_acts = 0;

  // driver: hold the request until taken, log the expected read result
  task automatic issue(input logic [1:0] k, input logic [15:0] a, input logic [7:0] w);
    exp_t e;
    req = 1'b1; kind = k; addr = a; wdata = w;
    #1;
    while (!accept) @(negedge clk);
    last_acc = cyc;
    e.k = k; e.a = a;
    if (k == 2'b00) begin e.d = code_byte(a); sb.push_back(e); end
    else if (k == 2'b01) begin e.d = shadow[midx(a)]; sb.push_back(e); end
    else shadow[midx(a)] = w;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (ale) lat_lo = pdo;
      if (!psen_n || !rd_n || !wr_n || ale || poe) quiet_acts++;
      if (rvalid) begin
        if (sb.size() == 0) chk(0, "R11", "valid with nothing pending", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          if (e.k == 2'b00) begin
            chk(rdata == e.d, "R4", "code byte", rdata, e.d);
            chk(bslot == 7, "R4", "code valid slot", bslot, 7);
            chk({hi, lat_lo} == e.a, "R2", "code address", {hi, lat_lo}, e.a);
          end else begin
            chk(rdata == e.d, "R6", "data byte", rdata, e.d);
            chk(bslot == 10, "R6", "data valid slot", bslot, 10);
            chk({hi, lat_lo} == e.a, "R5", "data address", {hi, lat_lo}, e.a);
          end
        end
      end
      if (!psen_n) begin
        chk(bslot >= 4 && bslot <= 6, "R3", "psen slot", bslot, 4);
        chk(!poe, "R9", "oe under psen", poe, 0);
        chk(rd_n && wr_n, "R8", "strobe overlap", {rd_n, wr_n}, 3);
      end
      if (!rd_n) begin
        chk(bslot >= 2 && bslot <= 9, "R6", "rd slot", bslot, 2);
        chk(!poe, "R9", "oe under rd", poe, 0);
        chk(wr_n && psen_n, "R8", "strobe overlap", {wr_n, psen_n}, 3);
      end
      if (!wr_n) begin
        chk(bslot >= 2 && bslot <= 9, "R7", "wr slot", bslot, 2);
        chk(poe, "R7", "write byte driven", poe, 1);
      end
      if (ale) begin
        chk(bslot == 1 || bslot == 2 || bslot == 9 || bslot == 10, "R2", "ale slot", bslot, 1);
        chk(poe, "R5", "address driven under ale", poe, 1);
      end
      if (accept) chk(bslot == 7, "R10", "accept slot", bslot, 7);
    end
  end

  initial begin
    int t0;
    for (int i = 0; i < 256; i++) begin
      dmem[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    chk(psen_n && rd_n && wr_n, "R1", "strobes in reset", {psen_n, rd_n, wr_n}, 7);
    chk(!ale && !poe, "R1", "ale/oe in reset", {ale, poe}, 0);
    chk(!rvalid && !accept, "R1", "valid/accept in reset", {rvalid, accept}, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // code reads at address extremes and mixed patterns
    issue(2'b00, 16'h0000, 8'h00);
    issue(2'b00, 16'hFFFF, 8'h00);
    issue(2'b00, 16'h12FF, 8'h00);
    issue(2'b00, 16'hA55A, 8'h00);

    // write then read back the same location: hold-off of 24 clocks
    issue(2'b10, 16'h3412, 8'h5C);
    t0 = last_acc;
    issue(2'b01, 16'h3412, 8'h00);
    chk(last_acc - t0 == 24, "R10", "transfer spacing", last_acc - t0, 24);
    t0 = last_acc;
    issue(2'b00, 16'h0042, 8'h00);
    chk(last_acc - t0 == 12, "R10", "spacing after transfer", last_acc - t0, 12);

    // interleaved mix
    issue(2'b01, 16'h80C1, 8'h00);
    issue(2'b00, 16'h7E01, 8'h00);
    issue(2'b10, 16'hFF00, 8'hA3);
    issue(2'b00, 16'h0100, 8'h00);
    issue(2'b01, 16'hFF00, 8'h00);
    issue(2'b10, 16'h00FF, 8'h3C);
    issue(2'b01, 16'h00FF, 8'h00);

    // kind 11 is ignored
    repeat (40) @(negedge clk);
    chk(sb.size() == 0, "R11", "reads outstanding", sb.size(), 0);
    quiet_acts = 0;
    req = 1'b1; kind = 2'b11; addr = 16'h5555;
    for (int i = 0; i < 36; i++) begin
      @(negedge clk);
      if (accept) chk(0, "R10", "kind 11 accepted", 1, 0);
    end
    req = 1'b0;
    chk(quiet_acts == 0, "R10", "bus activity for kind 11", quiet_acts, 0);

    repeat (12) @(negedge clk);
    chk(sb.size() == 0, "R11", "reads outstanding at end", sb.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        chk(0, "R1", "watchdog expired", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule